// File: doc/BRIEF.md
# Prioritized Up/Down Step Counter

This block is a synchronous binary counter whose register moves by a programmable step on every rising clock edge. A direction input chooses between adding and subtracting the step. Arithmetic wraps modulo 2^WIDTH, so the count rolls over at both ends of its range.

Four commands can override counting: a synchronous clear, a hold, a fill that forces the register to all ones, and a load from a parallel input. These commands are resolved by a fixed priority. Clear wins over hold, hold over fill, fill over load, and load over counting. All commands take effect at the next rising edge. The only output is the registered count.

The block is meant for a datapath that needs a stepping index, or a timer that can be parked, forced to its ceiling, or seeded at any cycle. The count has no defined value until the first edge that samples clear high.

Top module: `step_counter`

## Requirements
- R1: `count_o` is a register output. It changes only at a rising edge of `clk_i`, and input changes between edges leave it unchanged.
- R2: When `sync_clr_i` is 1 at an edge, the count becomes 0 whatever the other inputs are.
- R3: When `hold_i` is 1 and clear is 0, the count keeps its value. Fill, load, step and direction have no effect.
- R4: When `fill_i` is 1 and neither clear nor hold is 1, the count becomes all ones (255 at the default width). Load and counting are ignored.
- R5: When `load_i` is 1 and clear, hold and fill are all 0, the count takes the value of `load_val_i`.
- R6: With no command asserted and `up_i` = 1, the count becomes count + `step_i`.
- R7: With no command asserted and `up_i` = 0, the count becomes count − `step_i`.
- R8: A `step_i` of 0 with no command asserted leaves the count unchanged in either direction.
- R9: Counting wraps modulo 2^WIDTH in both directions. For example, 250 + 10 gives 4 and 4 − 7 gives 253.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| sync_clr_i | input | 1 | Synchronous clear, highest priority |
| hold_i | input | 1 | Keep the present count |
| fill_i | input | 1 | Force the count to all ones |
| load_i | input | 1 | Load `load_val_i` into the count |
| load_val_i | input | WIDTH (8) | Parallel load value |
| up_i | input | 1 | 1 adds the step, 0 subtracts it |
| step_i | input | WIDTH (8) | Unsigned step magnitude |
| count_o | output | WIDTH (8) | Registered count |

## Verification
The functions that collide are the commands themselves. Fill and load are asserted in the same cycle, and so are hold with fill and load, and clear with hold. A nonzero step is applied at the same time, so that a wrong resolution would produce a distinct, visible value. In each collision the count is compared one edge later against the value that only the winning command can produce. For example, a preloaded 0x42 must survive hold combined with fill, and 255 must appear rather than the load value.

// File: rtl/step_counter_pkg.sv
package step_counter_pkg;

   // Action chosen for the next edge, listed from highest to lowest priority
   typedef enum logic [2:0] {
      ACT_CLEAR = 3'd0,
      ACT_KEEP  = 3'd1,
      ACT_FILL  = 3'd2,
      ACT_LOAD  = 3'd3,
      ACT_STEP  = 3'd4
   } act_e;

   // Adder organisation choices for the stepping datapath
   localparam int unsigned ADDER_SPLIT = 0;  // separate add and subtract, then mux
   localparam int unsigned ADDER_SHARED = 1; // one adder with conditional invert and carry-in

endpackage

// File: rtl/step_counter_arbiter.sv
module step_counter_arbiter
   import step_counter_pkg::*;
(
   input  logic clr_i,
   input  logic keep_i,
   input  logic fill_i,
   input  logic load_i,
   output act_e act_o
);

   // Fixed priority chain: clear > keep > fill > load > step
   always_comb begin
      if (clr_i)       act_o = ACT_CLEAR;
      else if (keep_i) act_o = ACT_KEEP;
      else if (fill_i) act_o = ACT_FILL;
      else if (load_i) act_o = ACT_LOAD;
      else             act_o = ACT_STEP;
   end

endmodule

// File: rtl/step_counter_stepper.sv
module step_counter_stepper
   import step_counter_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned ADDER_KIND = ADDER_SHARED
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] step_i,
   input  logic             up_i,
   output logic [WIDTH-1:0] stepped_o
);

   localparam logic [WIDTH-1:0] ZERO_EXT = '0;

   generate
      if (ADDER_KIND == ADDER_SPLIT) begin : g_split
         logic [WIDTH-1:0] sum_up;
         logic [WIDTH-1:0] sum_dn;
         always_comb begin
            sum_up    = cur_i + step_i;
            sum_dn    = cur_i - step_i;
            stepped_o = up_i ? sum_up : sum_dn;
         end
      end else begin : g_shared
         logic [WIDTH-1:0] operand;
         logic [WIDTH-1:0] carry_in;
         always_comb begin
            operand   = step_i ^ {WIDTH{~up_i}};
            carry_in  = ZERO_EXT | {{(WIDTH-1){1'b0}}, ~up_i};
            stepped_o = cur_i + operand + carry_in;
         end
      end
   endgenerate

endmodule

// File: rtl/step_counter_nextsel.sv
module step_counter_nextsel
   import step_counter_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  act_e             act_i,
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] stepped_i,
   input  logic [WIDTH-1:0] load_val_i,
   output logic [WIDTH-1:0] nxt_o
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   always_comb begin
      unique case (act_i)
         ACT_CLEAR: nxt_o = '0;
         ACT_KEEP:  nxt_o = cur_i;
         ACT_FILL:  nxt_o = ALL_ONES;
         ACT_LOAD:  nxt_o = load_val_i;
         ACT_STEP:  nxt_o = stepped_i;
         default:   nxt_o = '0;
      endcase
   end

endmodule

// File: rtl/step_counter.sv
module step_counter
   import step_counter_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned ADDER_KIND = ADDER_SHARED
) (
   input  logic             clk_i,
   input  logic             sync_clr_i,
   input  logic             hold_i,
   input  logic             fill_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             up_i,
   input  logic [WIDTH-1:0] step_i,
   output logic [WIDTH-1:0] count_o
);

   localparam logic [WIDTH-1:0] TOP_VALUE = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("step_counter: WIDTH must be at least 2");
      end
      if (ADDER_KIND > ADDER_SHARED) begin : g_bad_kind
         $error("step_counter: ADDER_KIND out of range");
      end
   endgenerate

   act_e             act;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] count_q;

   step_counter_arbiter u_arb (
      .clr_i  (sync_clr_i),
      .keep_i (hold_i),
      .fill_i (fill_i),
      .load_i (load_i),
      .act_o  (act)
   );

   step_counter_stepper #(
      .WIDTH      (WIDTH),
      .ADDER_KIND (ADDER_KIND)
   ) u_step (
      .cur_i     (count_q),
      .step_i    (step_i),
      .up_i      (up_i),
      .stepped_o (stepped)
   );

   step_counter_nextsel #(
      .WIDTH (WIDTH)
   ) u_sel (
      .act_i      (act),
      .cur_i      (count_q),
      .stepped_i  (stepped),
      .load_val_i (load_val_i),
      .nxt_o      (nxt)
   );

   always_ff @(posedge clk_i) begin
      count_q <= nxt;
   end

   assign count_o = count_q;

   // R2: a sampled clear yields zero one edge later
   a_r2_clear_zero: assert property (@(posedge clk_i)
      sync_clr_i |=> (count_o == '0));

   // R3: hold keeps the value whatever else is asserted
   a_r3_hold_keeps: assert property (@(posedge clk_i) disable iff (sync_clr_i)
      hold_i |=> (count_o == $past(count_o)));

   // R4: fill forces all ones when no higher command is present
   a_r4_fill_top: assert property (@(posedge clk_i) disable iff (sync_clr_i)
      (!hold_i && fill_i) |=> (count_o == TOP_VALUE));

   // R5: load takes the parallel value when nothing outranks it
   a_r5_load_val: assert property (@(posedge clk_i) disable iff (sync_clr_i)
      (!hold_i && !fill_i && load_i) |=> (count_o == $past(load_val_i)));

   // R6: counting up adds the step modulo 2^WIDTH
   a_r6_count_up: assert property (@(posedge clk_i) disable iff (sync_clr_i)
      (!hold_i && !fill_i && !load_i && up_i)
      |=> (count_o == WIDTH'($past(count_o) + $past(step_i))));

   // R7: counting down subtracts the step modulo 2^WIDTH
   a_r7_count_down: assert property (@(posedge clk_i) disable iff (sync_clr_i)
      (!hold_i && !fill_i && !load_i && !up_i)
      |=> (count_o == WIDTH'($past(count_o) - $past(step_i))));

   // R8: a zero step leaves the count unchanged
   a_r8_zero_step: assert property (@(posedge clk_i) disable iff (sync_clr_i)
      (!hold_i && !fill_i && !load_i && (step_i == '0)) |=> $stable(count_o));

endmodule

// File: tb/tb_step_counter.sv
`timescale 1ns/1ps
module tb_step_counter;

   localparam int W = 8;

   logic         clk_i = 1'b0;
   logic         sync_clr_i;
   logic         hold_i;
   logic         fill_i;
   logic         load_i;
   logic [W-1:0] load_val_i;
   logic         up_i;
   logic [W-1:0] step_i;
   logic [W-1:0] count_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   step_counter #(.WIDTH(W)) dut (
      .clk_i      (clk_i),
      .sync_clr_i (sync_clr_i),
      .hold_i     (hold_i),
      .fill_i     (fill_i),
      .load_i     (load_i),
      .load_val_i (load_val_i),
      .up_i       (up_i),
      .step_i     (step_i),
      .count_o    (count_o)
   );

   always #2.5 clk_i = ~clk_i;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Advance one edge and sample 1 ns after it
   task automatic tick();
      @(posedge clk_i);
      #1;
   endtask

   task automatic idle();
      sync_clr_i = 0; hold_i = 0; fill_i = 0; load_i = 0;
   endtask

   task automatic t_reset();
      sync_clr_i = 1; hold_i = 1; fill_i = 1; load_i = 1;
      load_val_i = 8'h5A; up_i = 1; step_i = 8'd9;
      tick();
      check("R2 clear overrides all", count_o, 8'd0);
      tick();
      check("R2 clear repeated", count_o, 8'd0);
      idle();
   endtask

   task automatic t_load_and_up();
      load_i = 1; load_val_i = 8'd10; step_i = 8'd3; up_i = 1;
      tick();
      check("R5 load value", count_o, 8'd10);
      idle();
      tick();
      check("R6 up by 3", count_o, 8'd13);
      tick();
      check("R6 up by 3 again", count_o, 8'd16);
   endtask

   task automatic t_down();
      up_i = 0; step_i = 8'd5;
      tick();
      check("R7 down by 5", count_o, 8'd11);
   endtask

   task automatic t_wrap();
      load_i = 1; load_val_i = 8'd250;
      tick();
      idle();
      up_i = 1; step_i = 8'd10;
      tick();
      check("R9 wrap up 250+10", count_o, 8'd4);
      up_i = 0; step_i = 8'd7;
      tick();
      check("R9 wrap down 4-7", count_o, 8'd253);
   endtask

   task automatic t_zero_step();
      step_i = 8'd0; up_i = 1;
      tick();
      check("R8 zero step up", count_o, 8'd253);
      up_i = 0;
      tick();
      check("R8 zero step down", count_o, 8'd253);
   endtask

   task automatic t_fill();
      fill_i = 1; load_i = 1; load_val_i = 8'h33; step_i = 8'd1; up_i = 1;
      tick();
      check("R4 fill beats load", count_o, 8'd255);
      idle();
      load_i = 1; load_val_i = 8'h33;
      tick();
      check("R5 load after fill", count_o, 8'h33);
      idle();
   endtask

   task automatic t_hold();
      load_i = 1; load_val_i = 8'h42;
      tick();
      idle();
      hold_i = 1; fill_i = 1; load_i = 1; load_val_i = 8'h07; step_i = 8'd20; up_i = 1;
      tick();
      check("R3 hold beats fill/load", count_o, 8'h42);
      fill_i = 0; load_i = 0; up_i = 0;
      tick();
      check("R3 hold beats step", count_o, 8'h42);
      idle();
   endtask

   task automatic t_clear_vs_hold();
      sync_clr_i = 1; hold_i = 1;
      tick();
      check("R2 clear beats hold", count_o, 8'd0);
      idle();
   endtask

   task automatic t_between_edges();
      load_i = 1; load_val_i = 8'd77;
      tick();
      check("R5 load 77", count_o, 8'd77);
      load_val_i = 8'd11; fill_i = 1; step_i = 8'd3;
      #1.5;
      check("R1 no change between edges", count_o, 8'd77);
      idle();
      up_i = 1;
      tick();
      check("R1 update at edge", count_o, 8'd80);
   endtask

   initial begin
      idle();
      load_val_i = '0; up_i = 1; step_i = '0;
      t_reset();
      t_load_and_up();
      t_down();
      t_wrap();
      t_zero_step();
      t_fill();
      t_hold();
      t_clear_vs_hold();
      t_between_edges();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: count=%0d expected=done", count_o);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule